// File: doc/BRIEF.md
# Scatter-Gather DMA Descriptor Walker

This block reads data from a 32-bit word-addressed memory bus and streams it, one word at a time, to a storage engine over a valid/ready port. Software programs a start address, a total byte count and a mode bit, then writes a start command.

In direct mode the start address is where the data begins. The block reads total/4 consecutive words from that address.

In scatter-gather mode the start address points to a chain of three-word descriptors. Each descriptor names one memory segment. The block fetches each descriptor, checks it, moves its segment, and continues until it reaches the descriptor that carries the end-of-table flag. Bit 0 of the start address picks how the next descriptor is found: by stepping 12 bytes forward, or by following the link word stored in the descriptor.

Any malformed descriptor, misaligned address or byte-count mismatch stops the walk and raises an error flag. That flag stays set until the next accepted start. A clean finish produces a one-cycle done pulse.

Top module: `sg_dma_walker`

## Requirements
- R1: After reset the following all read zero: the start register, `busy_o`, `err_o`, `done_o`, `mem_req_o` and `eng_valid_o`.
- R2: Register address 0 holds the start address. All 32 bits can be written and read back, bit 0 included. Address 1 holds the total byte count. Address 2 is control: bit 0 is the scatter-gather enable, and writing 1 to bit 1 issues a start.
- R3: In direct mode (enable 0), a start causes reads of total/4 words at ascending addresses start, start+4, and so on. Each word is delivered on the engine stream in read order.
- R4: In scatter-gather mode with start bit 0 equal to 0, the table base is the start value with bit 0 cleared. A descriptor at address D is read in this order: D+0 (segment address), D+4 (link), D+8 (byte count in bits [30:0], end flag in bit 31). Its segment words are read next, and the next descriptor is taken from D+12. The link word is ignored in this mode.
- R5: In scatter-gather mode with start bit 0 equal to 1, the next descriptor address is the link word of the current descriptor.
- R6: Once the segment of a descriptor whose end flag is 1 has been moved, no further memory read is issued.
- R7: Any of the following sets `err_o`, returns the block to idle, and moves no data of the offending segment: a zero or non-multiple-of-4 segment count, a segment address with bits [1:0] not zero, a table base with bit 1 set, a direct start address with bits [1:0] not zero, a direct total that is zero or not a multiple of 4, or, in linked mode, a non-final link with bits [1:0] not zero. `err_o` stays at 1 until the next accepted start clears it.
- R8: In scatter-gather mode, the walk aborts with `err_o` if the running sum of segment counts would exceed the programmed total, or if the final descriptor leaves the sum different from the total.
- R9: After the engine takes the last word of an error-free transfer, `done_o` is high for exactly one cycle. `done_o` is never high while `err_o` is high.
- R10: `mem_req_o` and `mem_addr_o` hold steady until `mem_ready_i` is high. A read completes in the cycle where both are high, with `mem_rdata_i` valid in that same cycle. Every requested address has bits [1:0] equal to zero.
- R11: `eng_valid_o` and `eng_data_o` hold steady until `eng_ready_i` is high.
- R12: A start command issued while `busy_o` is high has no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 start, 1 total, 2 control |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory byte address, word aligned |
| mem_ready_i | input | 1 | Memory accepts the request and returns data this cycle |
| mem_rdata_i | input | 32 | Memory read data |
| eng_valid_o | output | 1 | Stream word valid toward the engine |
| eng_data_o | output | 32 | Stream word |
| eng_ready_i | input | 1 | Engine takes the word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse on clean completion |
| err_o | output | 1 | Sticky abort flag |

## Verification
The bench sweeps direct transfers over several start addresses and every length from one to eight words. It runs descriptor chains of one to five entries in stepped order and one to four in linked order, always under random stalls on both the memory side and the engine side.

Each chain is surrounded by bait:
- In stepped order, a well-formed descriptor sits just past the final one. A walker that ignores the end flag would fetch it.
- In stepped order, every link word is an unaligned junk value. A walker that follows links there would fault.
- In linked order, a short end-flagged descriptor sits at the stepped position after each real one. A walker that steps instead of following links would read it and stop early.

The error cases place the fault in a middle descriptor. A design that checked counts only after moving the data, or that forgot to make the flag sticky, would show extra reads or a cleared `err_o`. A second start issued mid-transfer, together with a rewrite of the start address, catches a design that restarts while busy.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned WORD_BYTES  = 4;
  localparam int unsigned DESC_WORDS  = 3;
  localparam int unsigned DESC_STRIDE = DESC_WORDS * WORD_BYTES;

  typedef enum logic [1:0] {
    RA_START = 2'd0,
    RA_TOTAL = 2'd1,
    RA_CTRL  = 2'd2
  } reg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_D0,
    ST_D1,
    ST_D2,
    ST_XFER,
    ST_DRAIN
  } walk_state_e;
endpackage

// File: rtl/sgw_regs.sv
module sgw_regs
  import sgw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [AW-1:0] wdata_i,
  output logic [AW-1:0] rdata_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] total_o,
  output logic          sg_en_o,
  output logic          go_o
);
  logic [AW-1:0] start_q, total_q;
  logic          sg_en_q, go_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      total_q <= '0;
      sg_en_q <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= we_i && (addr_i == RA_CTRL) && wdata_i[1];
      if (we_i) begin
        case (addr_i)
          RA_START: start_q <= wdata_i;
          RA_TOTAL: total_q <= wdata_i;
          RA_CTRL:  sg_en_q <= wdata_i[0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      RA_START: rdata_o = start_q;
      RA_TOTAL: rdata_o = total_q;
      RA_CTRL:  rdata_o = {{(AW-1){1'b0}}, sg_en_q};
      default:  rdata_o = '0;
    endcase
  end

  assign start_o = start_q;
  assign total_o = total_q;
  assign sg_en_o = sg_en_q;
  assign go_o    = go_q;
endmodule

// File: rtl/sgw_outbuf.sv
module sgw_outbuf #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          free_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign free_o  = !valid_q || ready_i;

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o));

  a_r11_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> free_o);
endmodule

// File: rtl/sgw_seq.sv
module sgw_seq
  import sgw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] total_i,
  input  logic          sg_en_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [AW-1:0] mem_rdata_i,
  input  logic          buf_free_i,
  input  logic          buf_valid_i,
  output logic          buf_load_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int unsigned CW = AW - 1;  // segment count field
  localparam int unsigned SW = AW + 1;  // running sum, no overflow
  localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);
  localparam logic [AW-1:0] STEP2  = AW'(2 * WORD_BYTES);
  localparam logic [AW-1:0] STRIDE = AW'(DESC_STRIDE);

  walk_state_e   state_q;
  logic [AW-1:0] desc_q, seg_addr_q, seg_rem_q, next_q, total_q;
  logic [SW-1:0] sum_q;
  logic          order_q, eot_q, done_q, err_q;
  logic          acc;
  logic [CW-1:0] d_cnt;
  logic          d_eot, d_bad;
  logic [SW-1:0] d_sum, tot_ext;

  assign d_cnt   = mem_rdata_i[CW-1:0];
  assign d_eot   = mem_rdata_i[AW-1];
  assign d_sum   = sum_q + SW'(d_cnt);
  assign tot_ext = {1'b0, total_q};

  // descriptor sanity, evaluated as the count word arrives
  always_comb begin
    d_bad = (seg_addr_q[1:0] != 2'b00) || (d_cnt == '0) || (d_cnt[1:0] != 2'b00)
         || (d_sum > tot_ext) || (d_eot && (d_sum != tot_ext))
         || (order_q && !d_eot && (next_q[1:0] != 2'b00));
  end

  always_comb begin
    mem_req_o  = 1'b0;
    mem_addr_o = seg_addr_q;
    case (state_q)
      ST_D0:   begin mem_req_o = 1'b1; mem_addr_o = desc_q;         end
      ST_D1:   begin mem_req_o = 1'b1; mem_addr_o = desc_q + STEP;  end
      ST_D2:   begin mem_req_o = 1'b1; mem_addr_o = desc_q + STEP2; end
      ST_XFER: mem_req_o = buf_free_i;
      default: ;
    endcase
  end

  assign acc        = mem_req_o && mem_ready_i;
  assign buf_load_o = (state_q == ST_XFER) && acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      desc_q     <= '0;
      seg_addr_q <= '0;
      seg_rem_q  <= '0;
      next_q     <= '0;
      total_q    <= '0;
      sum_q      <= '0;
      order_q    <= 1'b0;
      eot_q      <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (go_i) begin
          err_q   <= 1'b0;
          total_q <= total_i;
          sum_q   <= '0;
          if (sg_en_i) begin
            order_q <= start_i[0];
            desc_q  <= {start_i[AW-1:1], 1'b0};
            if (start_i[1]) err_q <= 1'b1;
            else            state_q <= ST_D0;
          end else begin
            seg_addr_q <= start_i;
            seg_rem_q  <= total_i;
            eot_q      <= 1'b1;
            if ((start_i[1:0] != 2'b00) || (total_i == '0) || (total_i[1:0] != 2'b00))
              err_q <= 1'b1;
            else
              state_q <= ST_XFER;
          end
        end
        ST_D0: if (acc) begin
          seg_addr_q <= mem_rdata_i;
          state_q    <= ST_D1;
        end
        ST_D1: if (acc) begin
          next_q  <= mem_rdata_i;
          state_q <= ST_D2;
        end
        ST_D2: if (acc) begin
          if (d_bad) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            seg_rem_q <= AW'(d_cnt);
            eot_q     <= d_eot;
            sum_q     <= d_sum;
            state_q   <= ST_XFER;
          end
        end
        ST_XFER: if (acc) begin
          seg_addr_q <= seg_addr_q + STEP;
          seg_rem_q  <= seg_rem_q - STEP;
          if (seg_rem_q == STEP) begin
            if (eot_q) begin
              state_q <= ST_DRAIN;
            end else begin
              desc_q  <= order_q ? next_q : desc_q + STRIDE;
              state_q <= ST_D0;
            end
          end
        end
        ST_DRAIN: if (!buf_valid_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o));

  a_r10_word_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_not_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !err_o);

  a_r7_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !busy_o && !buf_load_o);
endmodule

// File: rtl/sg_dma_walker.sv
module sg_dma_walker #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          eng_valid_o,
  output logic [AW-1:0] eng_data_o,
  input  logic          eng_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  logic [AW-1:0] start_w, total_w;
  logic          sg_en_w, go_w;
  logic          buf_free_w, buf_load_w;

  sgw_regs #(.AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .start_o (start_w),
    .total_o (total_w),
    .sg_en_o (sg_en_w),
    .go_o    (go_w)
  );

  sgw_seq #(.AW(AW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go_w),
    .start_i     (start_w),
    .total_i     (total_w),
    .sg_en_i     (sg_en_w),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .buf_free_i  (buf_free_w),
    .buf_valid_i (eng_valid_o),
    .buf_load_o  (buf_load_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  sgw_outbuf #(.DW(AW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (buf_load_w),
    .data_i  (mem_rdata_i),
    .ready_i (eng_ready_i),
    .valid_o (eng_valid_o),
    .data_o  (eng_data_o),
    .free_o  (buf_free_w)
  );
endmodule

// File: tb/tb_sg_dma_walker.sv
`timescale 1ns/1ps
module tb_sg_dma_walker;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_ready, eng_valid, eng_ready, busy, done, err;
  logic [31:0] mem_addr, mem_rdata, eng_data;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] mem [0:255];

  int n_chk = 0, n_fail = 0;
  logic [31:0] got_addr [0:LOGN-1];
  logic [31:0] got_data [0:LOGN-1];
  int got_an = 0, got_dn = 0, done_cnt = 0;
  logic [31:0] exp_addr [0:511];
  logic [31:0] exp_data [0:511];
  int exp_an, exp_dn;
  bit exp_err;

  always #4 clk = ~clk;

  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign mem_ready = lfsr[0] | lfsr[3];
  assign eng_ready = lfsr[6] | lfsr[11];
  assign mem_rdata = mem[mem_addr[9:2]];

  sg_dma_walker dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .eng_valid_o(eng_valid), .eng_data_o(eng_data), .eng_ready_i(eng_ready),
    .busy_o(busy), .done_o(done), .err_o(err)
  );

  // handshakes seen at negedge complete at the following posedge
  always @(negedge clk) begin
    if (mem_req && mem_ready) begin got_addr[got_an % LOGN] = mem_addr; got_an++; end
    if (eng_valid && eng_ready) begin got_data[got_dn % LOGN] = eng_data; got_dn++; end
    if (done) done_cnt++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic push_seg(input logic [31:0] a);
    exp_addr[exp_an] = a; exp_an++;
    exp_data[exp_dn] = rd(a); exp_dn++;
  endtask

  task automatic push_a(input logic [31:0] a);
    exp_addr[exp_an] = a; exp_an++;
  endtask

  task automatic ref_walk(input bit sg, input logic [31:0] start, input logic [31:0] total);
    logic [31:0] d, sa, nx, w;
    logic [32:0] sum, ns;
    bit ord, e, stop;
    exp_an = 0; exp_dn = 0; exp_err = 0;
    if (!sg) begin
      if (start[1:0] != 0 || total == 0 || total[1:0] != 0) exp_err = 1;
      else for (int i = 0; i < int'(total >> 2); i++) push_seg(start + 32'(4 * i));
    end else begin
      d = {start[31:1], 1'b0}; ord = start[0]; sum = '0; stop = 0;
      if (d[1]) begin exp_err = 1; stop = 1; end
      for (int k = 0; k < 16 && !stop; k++) begin
        push_a(d); push_a(d + 4); push_a(d + 8);
        sa = rd(d); nx = rd(d + 4); w = rd(d + 8);
        ns = sum + {2'b00, w[30:0]};
        e = w[31];
        if (sa[1:0] != 0 || w[30:0] == 0 || w[1:0] != 0 || ns > {1'b0, total}
            || (e && ns != {1'b0, total}) || (ord && !e && nx[1:0] != 0)) begin
          exp_err = 1; stop = 1;
        end else begin
          for (int i = 0; i < int'(w[30:0] >> 2); i++) push_seg(sa + 32'(4 * i));
          sum = ns;
          if (e) stop = 1;
          else d = ord ? nx : d + 12;
        end
      end
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] seg, input logic [31:0] nxt,
                          input logic [31:0] cnt, input bit eot);
    mem[a[9:2]] = seg;
    mem[(a + 4) >> 2] = nxt;
    mem[(a + 8) >> 2] = {eot, cnt[30:0]};
  endtask

  task automatic clear_desc();
    for (int i = 128; i < 256; i++) mem[i] = '0;
  endtask

  task automatic build_inorder(input int n, output logic [31:0] total);
    clear_desc(); total = '0;
    for (int k = 0; k < n; k++) begin
      put_desc(32'h200 + 32'(12 * k), 32'h10 + 32'(32'h30 * k), 32'hFFFF_FFF3,
               32'(4 * (k + 2)), k == n - 1);
      total += 32'(4 * (k + 2));
    end
    put_desc(32'h200 + 32'(12 * n), 32'h1F0, 32'h0, 32'd4, 1'b0);  // bait past end
  endtask

  function automatic logic [31:0] dptr(input int k);
    case (k)
      0: return 32'h300;
      1: return 32'h3C0;
      2: return 32'h330;
      3: return 32'h390;
      default: return 32'h360;
    endcase
  endfunction

  task automatic build_ooo(input int n, output logic [31:0] total);
    clear_desc(); total = '0;
    for (int k = 0; k < n; k++) begin
      put_desc(dptr(k), 32'hC0 + 32'(32'h14 * k), dptr(k + 1), 32'(4 * (4 - k)), k == n - 1);
      put_desc(dptr(k) + 12, 32'h1F0, 32'h0, 32'd4, 1'b1);  // bait at stepped slot
      total += 32'(4 * (4 - k));
    end
  endtask

  task automatic run(input bit sg, input logic [31:0] start, input logic [31:0] total,
                     input string tag, input bit poke);
    int a0, d0, k0, bad;
    logic [31:0] act, expv;
    ref_walk(sg, start, total);
    reg_wr(2'd0, start);
    reg_wr(2'd1, total);
    a0 = got_an; d0 = got_dn; k0 = done_cnt;
    reg_wr(2'd2, {30'd0, 1'b1, sg});
    if (poke) begin
      repeat (2) @(negedge clk);
      reg_wr(2'd0, 32'h40);
      reg_wr(2'd2, {30'd0, 1'b1, sg});
    end
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);

    bad = -1;
    for (int i = 0; i < exp_an && i < got_an - a0; i++)
      if (bad < 0 && got_addr[(a0 + i) % LOGN] !== exp_addr[i]) bad = i;
    if (got_an - a0 != exp_an) begin act = 32'(got_an - a0); expv = 32'(exp_an); end
    else if (bad >= 0) begin act = got_addr[(a0 + bad) % LOGN]; expv = exp_addr[bad]; end
    else begin act = '0; expv = '0; end
    check(got_an - a0 == exp_an && bad < 0, tag, "read address sequence", act, expv);

    bad = -1;
    for (int i = 0; i < exp_dn && i < got_dn - d0; i++)
      if (bad < 0 && got_data[(d0 + i) % LOGN] !== exp_data[i]) bad = i;
    if (got_dn - d0 != exp_dn) begin act = 32'(got_dn - d0); expv = 32'(exp_dn); end
    else if (bad >= 0) begin act = got_data[(d0 + bad) % LOGN]; expv = exp_data[bad]; end
    else begin act = '0; expv = '0; end
    check(got_dn - d0 == exp_dn && bad < 0, tag, "R11 stream words", act, expv);

    check(err == exp_err, tag, "err_o", 32'(err), 32'(exp_err));
    check(done_cnt - k0 == (exp_err ? 0 : 1), "R9", "done pulses", 32'(done_cnt - k0),
          exp_err ? 32'd0 : 32'd1);
  endtask

  initial begin
    logic [31:0] t;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 128; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h0001_0003);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_addr = 2'd0; #1;
    check(reg_rdata == 0, "R1", "start register", reg_rdata, 32'h0);
    check(!busy && !err && !done, "R1", "busy/err/done", {29'd0, busy, err, done}, 32'h0);
    check(!mem_req && !eng_valid, "R1", "mem_req/eng_valid", {30'd0, mem_req, eng_valid}, 32'h0);

    // R2 register access
    reg_wr(2'd0, 32'h1234_5679);
    #1 check(reg_rdata == 32'h1234_5679, "R2", "start readback", reg_rdata, 32'h1234_5679);
    reg_wr(2'd0, 32'hFFFF_FFFE);
    #1 check(reg_rdata == 32'hFFFF_FFFE, "R2", "start readback", reg_rdata, 32'hFFFF_FFFE);
    reg_wr(2'd1, 32'h0000_0ABC);
    reg_addr = 2'd1; #1;
    check(reg_rdata == 32'h0000_0ABC, "R2", "total readback", reg_rdata, 32'h0000_0ABC);
    reg_wr(2'd2, 32'h1);
    reg_addr = 2'd2; #1;
    check(reg_rdata == 32'h1 && !busy, "R2", "control readback", reg_rdata, 32'h1);

    // R3 direct sweep
    for (int s = 0; s < 4; s++)
      for (int len = 1; len <= 8; len++)
        run(1'b0, (s == 0) ? 32'h0 : (s == 1) ? 32'h4 : (s == 2) ? 32'h40 : 32'h7C,
            32'(4 * len), "R3 R10 R11", 1'b0);

    // R4 R6 stepped chains
    for (int n = 1; n <= 5; n++) begin
      build_inorder(n, t);
      run(1'b1, 32'h200, t, "R4 R6", 1'b0);
    end

    // R5 R6 linked chains, bit 0 masked off the table base
    for (int n = 1; n <= 4; n++) begin
      build_ooo(n, t);
      run(1'b1, 32'h301, t, "R5 R6", 1'b0);
    end

    // R7 zero count mid-chain, then stickiness
    build_inorder(3, t);
    mem[(32'h20C + 8) >> 2] = 32'h0;
    run(1'b1, 32'h200, t, "R7", 1'b0);
    repeat (20) @(negedge clk);
    check(err && !busy, "R7", "err sticky while idle", {30'd0, err, busy}, 32'h2);

    build_inorder(3, t);
    mem[(32'h20C + 8) >> 2] = 32'd6;
    run(1'b1, 32'h200, t, "R7", 1'b0);
    build_inorder(3, t);
    mem[32'h218 >> 2] = 32'h92;
    run(1'b1, 32'h200, t, "R7", 1'b0);
    build_inorder(3, t);
    run(1'b1, 32'h202, t, "R7", 1'b0);
    run(1'b0, 32'h6, 32'd8, "R7", 1'b0);
    run(1'b0, 32'h0, 32'd0, "R7", 1'b0);
    run(1'b0, 32'h0, 32'd10, "R7", 1'b0);
    build_ooo(3, t);
    mem[32'h304 >> 2] = 32'h3C2;
    run(1'b1, 32'h301, t, "R7", 1'b0);

    // R7 error cleared by a following clean start
    run(1'b0, 32'h20, 32'd12, "R7 R3", 1'b0);

    // R8 total mismatch
    build_inorder(4, t);
    run(1'b1, 32'h200, t - 32'd12, "R8", 1'b0);
    build_inorder(4, t);
    run(1'b1, 32'h200, t + 32'd4, "R8", 1'b0);
    build_ooo(3, t);
    run(1'b1, 32'h301, t - 32'd4, "R8", 1'b0);

    // R12 second start while busy
    run(1'b0, 32'h80, 32'd64, "R12", 1'b1);
    build_inorder(4, t);
    run(1'b1, 32'h200, t, "R12 R4", 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule